// File: doc/BRIEF.md
# Two-Way Set-Associative Copy-Back Data Cache

This block is an 8 Kbyte data cache that sits between a processor port and a slower main-memory port. The processor issues single-word reads and writes with a valid/ready handshake. A hit is answered in the same cycle the request is presented. A miss drops ready while the cache moves whole 16-byte lines over the memory port as bursts of four 32-bit beats. A refill brings a line in. When the line being replaced holds modified data, a write-back burst first sends it out.

Both ways of a set are read at once, and the tags are compared in parallel. The data of the matching way goes out through a two-input multiplexer. Writes stay in the cache and mark the line modified, so memory only sees that data when the line is evicted. A run-time selector picks how the replaced way is chosen: least recently accessed, alternating allocation, or a pseudo-random bit. An empty way always takes priority over the selected policy.

Top module: `cache_2way_cb`

## Requirements
- R1: An address splits into a tag `cpu_addr[31:12]`, a set index `cpu_addr[11:4]` and a word-in-line `cpu_addr[3:2]`. Words of the same line share one entry, and a tag never matches in both ways of a set.
- R2: A read that hits raises `cpu_ready` in the cycle the request is presented, with the addressed word on `cpu_rdata`, and causes no memory traffic.
- R3: A write that hits updates only the bytes whose `cpu_be` bit is set (bit k covers data bits 8k+7:8k). It completes with no stall and no memory traffic, and marks the line modified.
- R4: On a read miss `cpu_ready` stays low while the cache reads four beats from memory at the line base and the next three word addresses, in ascending order. It then returns the requested word.
- R5: When the replaced line is modified, the cache first writes all four of its words to memory at that line's own address (ascending word order, `mem_we` high), and only then starts the refill.
- R6: When the replaced line is unmodified, the refill starts at once with no write beats.
- R7: All lines are invalid after reset, and an invalid way is always filled before any valid way is replaced, whatever the policy.
- R8: With `policy_sel` = 0, each set records the way last accessed (hit or fill), and a miss replaces the other way.
- R9: With `policy_sel` = 1, each set records the way last filled, and a miss replaces the other way. Hits do not change this record.
- R10: With `policy_sel` = 2 or 3, the replaced way is the low bit of a free-running, never-zero 16-bit LFSR, so either way can be chosen over a run of misses.
- R11: A write miss allocates. It performs any needed write-back and the refill, then merges the write data under `cpu_be`, leaving the line modified.
- R12: A memory beat transfers on a cycle with both `mem_req` and `mem_ack` high. Until then `mem_req`, `mem_we` and `mem_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Replacement policy: 0 last-accessed, 1 alternating allocation, 2/3 pseudo-random |
| cpu_valid | input | 1 | Processor request present; held until accepted |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write-back beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, taken with mem_ack |
| mem_ack | input | 1 | Beat completes this cycle |

## Verification
The bench goes after replacement decisions that only one policy would make. One case evicts the way hit most recently, which only alternating allocation may do, and another checks that a modified line is sent out before the refill. A cache that merged the policies would keep the wrong line, and the wrong way then misses on a later access. A design that dropped the write-back, or wrote it after the refill, shows up in the order and addresses of the logged memory beats. A missing byte merge on a write miss, or a dirty bit left clear, returns stale data or shows no write beats when that line is evicted. A random policy stuck on one way is caught because one kind of eviction never happens.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WBACK = 2'd1,
        S_FILL  = 2'd2
    } fsm_e;

    localparam logic [1:0] POL_LAST_USED  = 2'd0;
    localparam logic [1:0] POL_ALTERNATE  = 2'd1;
endpackage

// File: rtl/cache_way_store.sv
module cache_way_store
    import cache_pkg::*;
#(
    parameter int SETS       = 256,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 20
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [$clog2(SETS)-1:0]             idx,
    output logic [TAG_W-1:0]                    rd_tag,
    output logic                                rd_valid,
    output logic                                rd_dirty,
    output logic [LINE_WORDS-1:0][WORD_W-1:0]   rd_line,
    input  logic                                wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0]       wr_word,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic [BE_W-1:0]                     wr_be,
    input  logic                                install,
    input  logic [TAG_W-1:0]                    install_tag,
    input  logic                                mark_dirty
);
    logic [TAG_W-1:0]                  tag_q  [SETS];
    logic [LINE_WORDS-1:0][WORD_W-1:0] data_q [SETS];
    logic [SETS-1:0] valid_d, valid_q;
    logic [SETS-1:0] dirty_d, dirty_q;

    assign rd_tag   = tag_q[idx];
    assign rd_line  = data_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (install) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = 1'b0;
        end
        if (mark_dirty) begin
            dirty_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= install_tag;
        end
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    data_q[idx][wr_word][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    // A line can only be marked modified while it holds valid data (R3)
    p_dirty_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |-> valid_q[idx]);

    // A line being installed cannot also be written by the processor (R11)
    p_install_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> !dirty_q[$past(idx)]);
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick
    import cache_pkg::*;
#(
    parameter int SETS = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              policy,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic                    valid0,
    input  logic                    valid1,
    input  logic                    touch_en,
    input  logic                    touch_way,
    input  logic                    alloc_en,
    input  logic                    alloc_way,
    output logic                    victim
);
    localparam logic [15:0] SEED = 16'hACE1;

    typedef struct packed {
        logic [SETS-1:0] last_used;
        logic [SETS-1:0] last_alloc;
        logic [15:0]     lfsr;
    } pick_t;

    pick_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lfsr = {st_q.lfsr[14:0],
                     st_q.lfsr[15] ^ st_q.lfsr[13] ^ st_q.lfsr[12] ^ st_q.lfsr[10]};
        if (touch_en) begin
            st_d.last_used[idx] = touch_way;
        end
        if (alloc_en) begin
            st_d.last_used[idx]  = alloc_way;
            st_d.last_alloc[idx] = alloc_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last_used  <= '0;
            st_q.last_alloc <= '0;
            st_q.lfsr       <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!valid0) begin
            victim = 1'b0;
        end else if (!valid1) begin
            victim = 1'b1;
        end else begin
            case (policy)
                POL_LAST_USED: victim = ~st_q.last_used[idx];
                POL_ALTERNATE: victim = ~st_q.last_alloc[idx];
                default:       victim = st_q.lfsr[0];
            endcase
        end
    end

    // The random source never locks up at zero (R10)
    p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != 16'h0000);

    // Hits leave the allocation record untouched (R9)
    p_alloc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !alloc_en) |=> $stable(st_q.last_alloc));
endmodule

// File: rtl/cache_2way_cb.sv
module cache_2way_cb
    import cache_pkg::*;
#(
    parameter int SETS       = 256,
    parameter int LINE_WORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          policy_sel,
    input  logic                cpu_valid,
    output logic                cpu_ready,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0]   cpu_wdata,
    input  logic [BE_W-1:0]     cpu_be,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int BEAT_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BEAT_W + 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

    typedef struct packed {
        fsm_e               state;
        logic [BEAT_W-1:0]  beat;
        logic               way;
        logic [TAG_W-1:0]   tag;
        logic [IDX_W-1:0]   idx;
        logic [TAG_W-1:0]   vtag;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [BEAT_W-1:0] req_word;
    logic [IDX_W-1:0]  lk_idx;
    logic              unused_low;

    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx    = cpu_addr[OFF_W +: IDX_W];
    assign req_word   = cpu_addr[2 +: BEAT_W];
    assign unused_low = ^cpu_addr[1:0];
    assign lk_idx     = (st_q.state == S_IDLE) ? req_idx : st_q.idx;

    logic [TAG_W-1:0]                  w_tag  [2];
    logic [LINE_WORDS-1:0][WORD_W-1:0] w_line [2];
    logic [1:0] w_valid, w_dirty, hit;
    logic [1:0] wr_en, install, mark_dirty;
    logic [BEAT_W-1:0] wr_word;
    logic [WORD_W-1:0] wr_data;
    logic [BE_W-1:0]   wr_be;
    logic hit_any, hit_way, victim, touch_en, alloc_en;

    for (genvar g = 0; g < 2; g++) begin : g_way
        cache_way_store #(
            .SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)
        ) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .idx        (lk_idx),
            .rd_tag     (w_tag[g]),
            .rd_valid   (w_valid[g]),
            .rd_dirty   (w_dirty[g]),
            .rd_line    (w_line[g]),
            .wr_en      (wr_en[g]),
            .wr_word    (wr_word),
            .wr_data    (wr_data),
            .wr_be      (wr_be),
            .install    (install[g]),
            .install_tag(st_q.tag),
            .mark_dirty (mark_dirty[g])
        );
        assign hit[g] = w_valid[g] && (w_tag[g] == req_tag);
    end

    assign hit_any   = |hit;
    assign hit_way   = hit[1];
    assign cpu_ready = (st_q.state == S_IDLE) && cpu_valid && hit_any;
    assign cpu_rdata = w_line[hit_way][req_word];
    assign touch_en  = cpu_ready;

    cache_victim_pick #(.SETS(SETS)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .policy   (policy_sel),
        .idx      (lk_idx),
        .valid0   (w_valid[0]),
        .valid1   (w_valid[1]),
        .touch_en (touch_en),
        .touch_way(hit_way),
        .alloc_en (alloc_en),
        .alloc_way(st_q.way),
        .victim   (victim)
    );

    always_comb begin
        st_d       = st_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        wr_en      = '0;
        install    = '0;
        mark_dirty = '0;
        wr_word    = req_word;
        wr_data    = cpu_wdata;
        wr_be      = cpu_be;
        alloc_en   = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (cpu_valid && hit_any && cpu_we) begin
                    wr_en[hit_way]      = 1'b1;
                    mark_dirty[hit_way] = 1'b1;
                end else if (cpu_valid && !hit_any) begin
                    st_d.way  = victim;
                    st_d.tag  = req_tag;
                    st_d.idx  = req_idx;
                    st_d.vtag = w_tag[victim];
                    st_d.beat = '0;
                    st_d.state = (w_valid[victim] && w_dirty[victim]) ? S_WBACK : S_FILL;
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {st_q.vtag, st_q.idx, st_q.beat, 2'b00};
                mem_wdata = w_line[st_q.way][st_q.beat];
                if (mem_ack) begin
                    st_d.beat = st_q.beat + BEAT_W'(1);
                    if (st_q.beat == LAST_BEAT) begin
                        st_d.beat  = '0;
                        st_d.state = S_FILL;
                    end
                end
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {st_q.tag, st_q.idx, st_q.beat, 2'b00};
                if (mem_ack) begin
                    wr_en[st_q.way] = 1'b1;
                    wr_word         = st_q.beat;
                    wr_data         = mem_rdata;
                    wr_be           = '1;
                    st_d.beat       = st_q.beat + BEAT_W'(1);
                    if (st_q.beat == LAST_BEAT) begin
                        install[st_q.way] = 1'b1;
                        alloc_en          = 1'b1;
                        st_d.beat         = '0;
                        st_d.state        = S_IDLE;
                    end
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: S_IDLE, beat: '0, way: 1'b0, tag: '0, idx: '0, vtag: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // One tag never resides in both ways of a set (R1)
    p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_IDLE) |-> !(hit[0] && hit[1]));

    // The processor is held off while the memory port is busy (R4)
    p_quiet_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // A refill entered straight from lookup must replace an unmodified line (R5)
    p_clean_before_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_FILL && $past(st_q.state) == S_IDLE)
            |-> !(w_valid[st_q.way] && w_dirty[st_q.way]));

    // An empty way 0 is the one chosen for replacement (R7)
    p_empty_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_IDLE && cpu_valid && !hit_any && !w_valid[0]) |=> (st_q.way == 1'b0));

    // A pending beat keeps its command steady (R12)
    p_burst_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
endmodule

// File: tb/test_cache_2way_cb.sv
module test_cache_2way_cb;
    localparam int CLK_PERIOD = 10;
    localparam int LOG_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  policy_sel = 2'd0;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    cache_2way_cb i_cache_2way_cb (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Main memory contents, backing default, and the processor-visible reference
    logic [31:0] mem_q [logic [31:0]];
    logic [31:0] ref_q [logic [31:0]];
    logic        ev_we   [LOG_N];
    logic [31:0] ev_addr [LOG_N];
    logic [31:0] ev_data [LOG_N];
    int          ev_n = 0;

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ 32'hA5A5_0F0F;
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        return mem_q.exists(a) ? mem_q[a] : init_word(a);
    endfunction

    function automatic logic [31:0] ref_read(input logic [31:0] a);
        return ref_q.exists(a) ? ref_q[a] : init_word(a);
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return (32'(tag) << 12) | (32'(set) << 4) | (32'(word) << 2);
    endfunction

    // Memory responder: one beat every second cycle, acts away from the rising edge
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_q[mem_addr] = mem_wdata;
            end else begin
                mem_rdata <= mem_read(mem_addr);
            end
            if (ev_n < LOG_N) begin
                ev_we[ev_n]   = mem_we;
                ev_addr[ev_n] = mem_addr;
                ev_data[ev_n] = mem_wdata;
            end
            ev_n = ev_n + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int stall);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_be    = be;
        stall     = 0;
        while (1) begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            stall++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
        if (we) begin
            logic [31:0] w;
            w = ref_read(a);
            for (int b = 0; b < 4; b++) begin
                if (be[b]) w[8*b +: 8] = d[8*b +: 8];
            end
            ref_q[a] = w;
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 32'h0000_1010, 32'h0,          4'h0},
        '{1'b1, 32'h0000_1018, 32'h1122_3344, 4'hF},
        '{1'b0, 32'h0000_1018, 32'h0,          4'h0},
        '{1'b0, 32'h0000_2014, 32'h0,          4'h0},
        '{1'b1, 32'h0000_302C, 32'hAABB_CCDD, 4'h5},
        '{1'b0, 32'h0000_302C, 32'h0,          4'h0},
        '{1'b0, 32'h0000_4010, 32'h0,          4'h0},
        '{1'b0, 32'h0000_1018, 32'h0,          4'h0},
        '{1'b1, 32'h0000_5030, 32'h9900_0000, 4'h8},
        '{1'b0, 32'h0000_5030, 32'h0,          4'h0},
        '{1'b0, 32'h0000_101C, 32'h0,          4'h0},
        '{1'b0, 32'h0000_4014, 32'h0,          4'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int st, e0;
        int ev_tag, resident0, resident1, newer, took_new, took_old;
        bit ok;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R7: nothing valid after reset, no memory activity
        check(cpu_ready == 1'b0, "R7", "ready after reset", 32'(cpu_ready), 32'h0);
        check(mem_req == 1'b0, "R7", "mem_req after reset", 32'(mem_req), 32'h0);

        // Table walk, last-accessed policy; every read checked against the reference
        policy_sel = 2'd0;
        foreach (VEC[i]) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].be, rd, st);
            if (!VEC[i].we)
                check(rd == ref_read(VEC[i].addr), "R4", $sformatf("table read %0d", i),
                      rd, ref_read(VEC[i].addr));
        end

        // R4: read miss fetches four ascending beats from the line base
        e0 = ev_n;
        access(1'b0, mk(7, 40, 0), 0, 0, rd, st);
        ok = (ev_n - e0 == 4);
        for (int k = 0; k < 4; k++)
            if (ok && (ev_we[e0+k] || ev_addr[e0+k] != mk(7, 40, k))) ok = 0;
        check(ok && st > 0, "R4", "refill beats", 32'(ev_n - e0), 32'd4);
        check(rd == init_word(mk(7, 40, 0)), "R4", "miss data", rd, init_word(mk(7, 40, 0)));

        // R1 / R2: another word of the same line hits at once with no memory traffic
        e0 = ev_n;
        access(1'b0, mk(7, 40, 3), 0, 0, rd, st);
        check(st == 0 && ev_n == e0, "R2", "hit stall", 32'(st), 32'h0);
        check(rd == init_word(mk(7, 40, 3)), "R1", "same-line word", rd, init_word(mk(7, 40, 3)));

        // R3: byte-enabled write hit, no stall, no memory traffic
        e0 = ev_n;
        access(1'b1, mk(7, 40, 1), 32'h0000_BEEF, 4'h3, rd, st);
        check(st == 0 && ev_n == e0, "R3", "write hit traffic", 32'(ev_n - e0), 32'h0);
        access(1'b0, mk(7, 40, 1), 0, 0, rd, st);
        check(rd == ref_read(mk(7, 40, 1)), "R3", "byte merge", rd, ref_read(mk(7, 40, 1)));

        // R6 / R8: last-accessed policy replaces the clean, older way
        access(1'b1, mk(10, 41, 0), 32'hCAFE_0001, 4'hF, rd, st);
        access(1'b0, mk(11, 41, 0), 0, 0, rd, st);
        access(1'b0, mk(10, 41, 0), 0, 0, rd, st);
        e0 = ev_n;
        access(1'b0, mk(12, 41, 0), 0, 0, rd, st);
        ok = (ev_n - e0 == 4);
        for (int k = 0; k < 4; k++) if (ok && ev_we[e0+k]) ok = 0;
        check(ok, "R6", "clean victim no write-back", 32'(ev_n - e0), 32'd4);
        access(1'b0, mk(10, 41, 0), 0, 0, rd, st);
        check(st == 0, "R8", "recently used line kept", 32'(st), 32'h0);

        // R5: modified victim is written out in full before the refill
        access(1'b0, mk(12, 41, 0), 0, 0, rd, st);
        e0 = ev_n;
        access(1'b0, mk(13, 41, 2), 0, 0, rd, st);
        ok = (ev_n - e0 == 8);
        for (int k = 0; k < 4; k++) begin
            if (ok && (!ev_we[e0+k] || ev_addr[e0+k] != mk(10, 41, k)
                       || ev_data[e0+k] != ref_read(mk(10, 41, k)))) ok = 0;
            if (ok && (ev_we[e0+4+k] || ev_addr[e0+4+k] != mk(13, 41, k))) ok = 0;
        end
        check(ok, "R5", "write-back then refill", 32'(ev_n - e0), 32'd8);
        check(rd == ref_read(mk(13, 41, 2)), "R5", "data after write-back", rd, ref_read(mk(13, 41, 2)));

        // R11: write miss allocates, merges, and leaves the line modified
        e0 = ev_n;
        access(1'b1, mk(30, 43, 2), 32'h0077_0000, 4'h4, rd, st);
        check(st > 0 && ev_n - e0 == 4, "R11", "write miss refill", 32'(ev_n - e0), 32'd4);
        access(1'b0, mk(30, 43, 2), 0, 0, rd, st);
        check(rd == ref_read(mk(30, 43, 2)), "R11", "write miss merge", rd, ref_read(mk(30, 43, 2)));
        access(1'b0, mk(31, 43, 0), 0, 0, rd, st);
        access(1'b0, mk(31, 43, 1), 0, 0, rd, st);
        e0 = ev_n;
        access(1'b0, mk(32, 43, 0), 0, 0, rd, st);
        check(ev_n - e0 == 8 && ev_we[e0] && ev_addr[e0+2] == mk(30, 43, 2)
              && ev_data[e0+2] == ref_read(mk(30, 43, 2)),
              "R11", "allocated line written back", ev_data[e0+2], ref_read(mk(30, 43, 2)));

        // R9: alternating allocation ignores hits
        policy_sel = 2'd1;
        access(1'b0, mk(20, 42, 0), 0, 0, rd, st);
        access(1'b0, mk(21, 42, 0), 0, 0, rd, st);
        for (int k = 0; k < 3; k++) access(1'b0, mk(20, 42, 1), 0, 0, rd, st);
        access(1'b0, mk(22, 42, 0), 0, 0, rd, st);
        access(1'b0, mk(21, 42, 0), 0, 0, rd, st);
        check(st == 0, "R9", "last-filled line survives", 32'(st), 32'h0);
        access(1'b0, mk(20, 42, 0), 0, 0, rd, st);
        check(st > 0, "R9", "frequently hit line replaced", 32'(st), 32'h1);

        // R7: empty ways fill first even under the random policy
        policy_sel = 2'd2;
        ok = 1;
        for (int s = 50; s < 56; s++) begin
            access(1'b0, mk(60, s, 0), 0, 0, rd, st);
            access(1'b0, mk(61, s, 0), 0, 0, rd, st);
            access(1'b0, mk(60, s, 1), 0, 0, rd, st);
            if (st != 0) ok = 0;
            access(1'b0, mk(61, s, 1), 0, 0, rd, st);
            if (st != 0) ok = 0;
        end
        check(ok, "R7", "both empty ways used", 32'(ok), 32'h1);

        // R10: random choice evicts both newer and older lines over a run
        access(1'b1, mk(40, 60, 0), 32'h4000_0000, 4'hF, rd, st);
        access(1'b1, mk(41, 60, 0), 32'h4100_0000, 4'hF, rd, st);
        resident0 = 40; resident1 = 41; newer = 41;
        took_new = 0; took_old = 0;
        ok = 1;
        for (int i = 0; i < 16; i++) begin
            repeat ((i % 3) + (i % 5)) @(negedge clk);
            e0 = ev_n;
            access(1'b1, mk(70 + i, 60, 0), 32'(i), 4'hF, rd, st);
            ev_tag = (ev_n > e0 && ev_we[e0]) ? int'(ev_addr[e0][31:12]) : -1;
            if (ev_tag != resident0 && ev_tag != resident1) ok = 0;
            if (ev_tag == newer) took_new++; else took_old++;
            if (ev_tag == resident0) resident0 = 70 + i; else resident1 = 70 + i;
            newer = 70 + i;
        end
        check(ok, "R10", "evicted line was resident", 32'(ok), 32'h1);
        check(took_new > 0 && took_old > 0, "R10", "both ways chosen",
              32'(took_new), 32'(took_old));

        // R12: refill data consistent after bursts under all policies
        policy_sel = 2'd0;
        access(1'b0, mk(13, 41, 3), 0, 0, rd, st);
        check(rd == ref_read(mk(13, 41, 3)), "R12", "burst word", rd, ref_read(mk(13, 41, 3)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule